// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a small timer peripheral behind a simple synchronous register bus. It holds two counters. The first is a down-counter of `PER_W` bits that counts on one of two externally supplied tick enables. In reload mode it restarts from a programmable period register each time it passes zero, so it gives a steady periodic interrupt. In free-run mode it restarts from all ones. Each pass through zero latches an interrupt level. That level stays high until software writes the clear register.

The second counter is `FREE_W` bits wide (40 by default). It counts down on its own tick enable whenever its enable bit is set. It never raises an interrupt. It serves as a high-resolution time base: software reads its low word and its high word at any time without disturbing it. The tick enables come from prescalers outside this block, and the interrupt output goes to an interrupt controller outside it.

Reads are combinational from the address. Writes take effect on the rising clock edge on which the write strobe is high.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, all registers read zero, both counters are zero and `irq_o` is low.
- R2: The control register at address 2 holds the run enable in bit 7, reload mode in bit 6 and tick source in bit 3, and its other bits read as zero. Writing 0x48 selects reload mode and leaves the counter stopped.
- R3: While bit 7 of the control register is clear, the periodic count holds its value, whatever the tick inputs do.
- R4: While the counter runs, it decrements by one for each cycle in which the selected tick is high. Bit 3 set selects `tick_src1_i` and bit 3 clear selects `tick_src0_i`. The other tick has no effect.
- R5: In reload mode, a selected tick that finds the count at zero loads the period register and sets the interrupt. A period value P therefore gives one underflow every P+1 ticks.
- R6: In free-run mode (bit 6 clear), a selected tick that finds the count at zero loads all ones (2^PER_W-1) and sets the interrupt.
- R7: A write to the period register (address 0) is applied on the first selected tick while the counter runs. On that tick the count takes the new value, with no decrement and no underflow. Until that tick the count is unchanged.
- R8: `irq_o` is a level that stays high until a write of any data to address 3. If an underflow happens in the same cycle as that write, `irq_o` stays high.
- R9: The wide counter decrements by one for each cycle in which `tick_free_i` is high while bit 8 of address 5 is set, and holds otherwise. It never affects `irq_o`.
- R10: Address 4 reads the wide count bits 31:0. Address 5 reads count bits 39:32 in bits 7:0 and the enable in bit 8. A write to address 5 changes only the enable, and reads never change either count.
- R11: Address 0 reads the period register (PER_W bits: wider write data is truncated and the upper read bits are zero). Address 1 reads the periodic count and ignores writes. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 3 | Register word address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| tick_src0_i | input | 1 | Tick enable used when control bit 3 is clear |
| tick_src1_i | input | 1 | Tick enable used when control bit 3 is set |
| tick_free_i | input | 1 | Tick enable for the wide free-running counter |
| irq_o | output | 1 | Underflow interrupt level |

## Verification
The bench builds the block with `PER_W` set to 12 and leaves `FREE_W` at 40. With a 12-bit period register, truncation of a wide write is visible, and the free-run reload value (0xFFF) is distinct from any 16-bit pattern. Starting the wide counter from zero makes its first tick wrap to all ones, which exercises both the low word and the high byte at once. Small period values make reload cadence, tick-source selection, deferred period loads and the clear-versus-underflow collision reachable in a few dozen cycles.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the reloading timer block.
// Assumes a 3-bit word address and a control layout whose bit positions
// are fixed by software that programs the block.
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PERIOD  = 3'd0,
        A_COUNT   = 3'd1,
        A_CTRL    = 3'd2,
        A_ACK     = 3'd3,
        A_FREE_LO = 3'd4,
        A_FREE_HI = 3'd5
    } reg_addr_e;

    localparam int CTRL_RUN_BIT    = 7;
    localparam int CTRL_RELOAD_BIT = 6;
    localparam int CTRL_SRC_BIT    = 3;
    localparam int FREE_EN_BIT     = 8;

    typedef struct packed {
        logic run;
        logic reload;
        logic src;
    } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Register write decode for the timer.
// Holds the period value, the control fields and the wide-counter enable.
// Produces one-cycle strobes for period writes and interrupt clears.
// Assumes writes are single-cycle strobes qualified by the address.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PER_W-1:0]  period_o,
    output ctrl_t             ctrl_o,
    output logic              free_en_o,
    output logic              period_wr_o,
    output logic              ack_wr_o
);

    logic unused_wdata;

    // Fold all write data bits so that the fields not decoded raise no warning.
    assign unused_wdata = ^wdata_i;

    // Strobes for the two registers whose writes have side effects.
    always_comb begin
        period_wr_o = wr_i && (addr_i == A_PERIOD);
        ack_wr_o    = wr_i && (addr_i == A_ACK);
    end

    // Capture the writable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_o  <= '0;
            ctrl_o    <= '0;
            free_en_o <= 1'b0;
        end else if (wr_i) begin
            case (addr_i)
                A_PERIOD:  period_o <= wdata_i[PER_W-1:0];
                A_CTRL: begin
                    ctrl_o.run    <= wdata_i[CTRL_RUN_BIT];
                    ctrl_o.reload <= wdata_i[CTRL_RELOAD_BIT];
                    ctrl_o.src    <= wdata_i[CTRL_SRC_BIT];
                end
                A_FREE_HI: free_en_o <= wdata_i[FREE_EN_BIT];
                default: ;
            endcase
        end
    end

    // R2
    ctrl_run_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CTRL) |=> (ctrl_o.run == $past(wdata_i[CTRL_RUN_BIT])));

    // R10
    free_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_FREE_HI) |=> $stable(free_en_o));

endmodule

// File: rtl/tmr_reload_cnt.sv
// Periodic down-counter with source selection, deferred period loads and
// underflow detection.
// Assumes tick inputs are single-cycle enables in the clk domain.
// The underflow output is a combinational pulse for the cycle of the tick.
module tmr_reload_cnt
    import tmr_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl_i,
    input  logic             tick0_i,
    input  logic             tick1_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             period_wr_i,
    output logic [PER_W-1:0] count_o,
    output logic             underflow_o
);

    localparam logic [PER_W-1:0] ALL_ONES = '1;

    logic tick_act;
    logic pend_q;
    logic at_zero;

    // Qualified tick: the chosen source, gated by the run bit.
    always_comb begin
        tick_act    = ctrl_i.run && (ctrl_i.src ? tick1_i : tick0_i);
        at_zero     = (count_o == '0);
        underflow_o = tick_act && !pend_q && at_zero;
    end

    // Remember a period write until a qualified tick applies it.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (period_wr_i) pend_q <= 1'b1;
        else if (tick_act)    pend_q <= 1'b0;
    end

    // Advance the count on each qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (tick_act) begin
            if (pend_q)       count_o <= period_i;
            else if (at_zero) count_o <= ctrl_i.reload ? period_i : ALL_ONES;
            else              count_o <= count_o - 1'b1;
        end
    end

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.run |=> $stable(count_o));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_act && !pend_q && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));

    // R6
    freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !ctrl_i.reload) |=> (count_o == ALL_ONES));

    // R7
    deferred_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_act && pend_q) |=> (count_o == $past(period_i)));

endmodule

// File: rtl/tmr_irq_hold.sv
// Interrupt level holder: set by an underflow pulse, cleared by a write
// strobe, with set taking priority when both arrive together.
// Assumes both inputs are synchronous one-cycle pulses.
module tmr_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    // Latch the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_o <= 1'b0;
        else if (set_i) irq_o <= 1'b1;
        else if (clr_i) irq_o <= 1'b0;
    end

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_i));

endmodule

// File: rtl/tmr_free_cnt.sv
// Wide free-running down-counter with an enable and no terminal action.
// Assumes the tick is a single-cycle enable; it wraps from zero to all ones.
module tmr_free_cnt #(
    parameter int FREE_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    output logic [FREE_W-1:0] count_o
);

    // Decrement on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_o <= '0;
        else if (en_i && tick_i) count_o <= count_o - 1'b1;
    end

    // R9
    free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && tick_i) |=> $stable(count_o));

    // R9
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i) |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/tick_timer_unit.sv
// Top of the reloading timer block: register decode, periodic counter,
// interrupt holder, wide free counter and combinational read mux.
// Assumes PER_W <= 32 and 32 < FREE_W <= 40, so that the high part of the
// wide count fits below the enable bit.
module tick_timer_unit
    import tmr_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int FREE_W = 40,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_src0_i,
    input  logic              tick_src1_i,
    input  logic              tick_free_i,
    output logic              irq_o
);

    localparam int HI_W = FREE_W - DATA_W;

    logic [PER_W-1:0]  period;
    ctrl_t             ctrl;
    logic              free_en;
    logic              period_wr;
    logic              ack_wr;
    logic [PER_W-1:0]  per_count;
    logic              underflow;
    logic [FREE_W-1:0] free_count;

    tmr_regs #(.PER_W(PER_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .period_o    (period),
        .ctrl_o      (ctrl),
        .free_en_o   (free_en),
        .period_wr_o (period_wr),
        .ack_wr_o    (ack_wr)
    );

    tmr_reload_cnt #(.PER_W(PER_W)) u_reload (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .tick0_i     (tick_src0_i),
        .tick1_i     (tick_src1_i),
        .period_i    (period),
        .period_wr_i (period_wr),
        .count_o     (per_count),
        .underflow_o (underflow)
    );

    tmr_irq_hold u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (underflow),
        .clr_i (ack_wr),
        .irq_o (irq_o)
    );

    tmr_free_cnt #(.FREE_W(FREE_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (free_en),
        .tick_i  (tick_free_i),
        .count_o (free_count)
    );

    // Select the addressed register onto the read bus.
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_PERIOD:  bus_rdata_o[PER_W-1:0] = period;
            A_COUNT:   bus_rdata_o[PER_W-1:0] = per_count;
            A_CTRL: begin
                bus_rdata_o[CTRL_RUN_BIT]    = ctrl.run;
                bus_rdata_o[CTRL_RELOAD_BIT] = ctrl.reload;
                bus_rdata_o[CTRL_SRC_BIT]    = ctrl.src;
            end
            A_FREE_LO: bus_rdata_o = free_count[DATA_W-1:0];
            A_FREE_HI: begin
                bus_rdata_o[HI_W-1:0]    = free_count[FREE_W-1:DATA_W];
                bus_rdata_o[FREE_EN_BIT] = free_en;
            end
            default:   bus_rdata_o = '0;
        endcase
    end

    // R9
    free_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!underflow && !irq_o) |=> !irq_o);

endmodule

// File: tb/tick_timer_unit_tb.sv
module tick_timer_unit_tb;

    localparam int CLK_NS = 20;
    localparam int PER_W  = 12;
    localparam int NV     = 16;

    // {req[3:0], is_read, addr[2:0], data[31:0]}
    localparam logic [39:0] VEC [NV] = '{
        {4'd2,  1'b0, 3'd2, 32'h0000_0048},
        {4'd2,  1'b1, 3'd2, 32'h0000_0048},
        {4'd2,  1'b0, 3'd2, 32'h0000_00FF},
        {4'd2,  1'b1, 3'd2, 32'h0000_00C8},
        {4'd2,  1'b0, 3'd2, 32'h0000_0000},
        {4'd11, 1'b0, 3'd1, 32'h0000_0055},
        {4'd11, 1'b1, 3'd1, 32'h0000_0000},
        {4'd11, 1'b1, 3'd6, 32'h0000_0000},
        {4'd11, 1'b1, 3'd7, 32'h0000_0000},
        {4'd11, 1'b0, 3'd0, 32'h0001_2345},
        {4'd11, 1'b1, 3'd0, 32'h0000_0345},
        {4'd10, 1'b0, 3'd5, 32'h0000_0100},
        {4'd10, 1'b1, 3'd5, 32'h0000_0100},
        {4'd10, 1'b0, 3'd5, 32'h0000_00FF},
        {4'd10, 1'b1, 3'd5, 32'h0000_0000},
        {4'd10, 1'b1, 3'd4, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        t0 = 1'b0;
    logic        t1 = 1'b0;
    logic        tf = 1'b0;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    tick_timer_unit #(.PER_W(PER_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_src0_i (t0),
        .tick_src1_i (t1),
        .tick_free_i (tf),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    // which: 0 = tick_src0_i, 1 = tick_src1_i, 2 = tick_free_i
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: t0 = 1'b1;
            1: t1 = 1'b1;
            default: tf = 1'b1;
        endcase
        @(negedge clk);
        t0 = 1'b0; t1 = 1'b0; tf = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: all requirements actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 period",  3'd0, 32'h0);
        rd_chk("R1 count",   3'd1, 32'h0);
        rd_chk("R1 ctrl",    3'd2, 32'h0);
        rd_chk("R1 free lo", 3'd4, 32'h0);
        rd_chk("R1 free hi", 3'd5, 32'h0);
        irq_chk("R1 irq", 1'b0);

        // Register table: R2, R10, R11
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            if (v[35])
                rd_chk($sformatf("R%0d table step %0d", v[39:36], i), v[34:32], v[31:0]);
            else
                bus_write(v[34:32], v[31:0]);
        end

        // R3: stopped counter ignores ticks
        bus_write(3'd2, 32'h48);
        bus_write(3'd0, 32'd4);
        pulse(1); pulse(1); pulse(1);
        rd_chk("R3 stopped count", 3'd1, 32'h0);
        irq_chk("R3 no irq", 1'b0);

        // R7: first tick after enabling applies the period write
        bus_write(3'd2, 32'hC8);
        pulse(1);
        rd_chk("R7 first tick loads", 3'd1, 32'd4);
        irq_chk("R7 no underflow", 1'b0);

        // R4: unselected tick ignored, then step down
        pulse(0);
        rd_chk("R4 other source ignored", 3'd1, 32'd4);
        for (int k = 3; k >= 0; k--) begin
            pulse(1);
            rd_chk("R4 decrement", 3'd1, k);
        end

        // R5: underflow reloads and raises irq
        pulse(1);
        rd_chk("R5 reload value", 3'd1, 32'd4);
        irq_chk("R5 irq raised", 1'b1);

        // R8: held without a clear, dropped by a clear write
        repeat (3) @(negedge clk);
        irq_chk("R8 irq held", 1'b1);
        bus_write(3'd3, 32'hDEAD);
        irq_chk("R8 irq cleared", 1'b0);

        // R5: period 4 gives an underflow every 5 ticks
        repeat (4) pulse(1);
        irq_chk("R5 no irq after 4 ticks", 1'b0);
        pulse(1);
        irq_chk("R5 irq on 5th tick", 1'b1);

        // R8: underflow and clear in the same cycle
        repeat (4) pulse(1);
        @(negedge clk);
        addr = 3'd3; wdata = 32'h0; wr = 1'b1; t1 = 1'b1;
        @(negedge clk);
        wr = 1'b0; t1 = 1'b0;
        irq_chk("R8 underflow beats clear", 1'b1);
        rd_chk("R5 count after collision", 3'd1, 32'd4);
        bus_write(3'd3, 32'h0);
        irq_chk("R8 clear alone", 1'b0);

        // R7: period write while running waits for a tick
        bus_write(3'd0, 32'd2);
        rd_chk("R7 unchanged before tick", 3'd1, 32'd4);
        pulse(1);
        rd_chk("R7 new period applied", 3'd1, 32'd2);
        pulse(1);
        rd_chk("R7 counts from new value", 3'd1, 32'd1);

        // R4 and R6: source 0, free-run mode
        bus_write(3'd2, 32'h80);
        pulse(1);
        rd_chk("R4 source 1 ignored", 3'd1, 32'd1);
        pulse(0);
        rd_chk("R4 source 0 counts", 3'd1, 32'd0);
        pulse(0);
        rd_chk("R6 wrap to all ones", 3'd1, 32'hFFF);
        irq_chk("R6 irq raised", 1'b1);
        bus_write(3'd3, 32'h1);

        // R9, R10: wide counter
        pulse(2); pulse(2);
        rd_chk("R9 disabled holds", 3'd4, 32'h0);
        bus_write(3'd5, 32'h100);
        pulse(2);
        rd_chk("R9 wrap low", 3'd4, 32'hFFFF_FFFF);
        rd_chk("R10 high word", 3'd5, 32'h1FF);
        pulse(2);
        rd_chk("R9 step", 3'd4, 32'hFFFF_FFFE);
        rd_chk("R10 reread stable", 3'd4, 32'hFFFF_FFFE);
        irq_chk("R9 no irq", 1'b0);
        bus_write(3'd5, 32'h0);
        pulse(2);
        rd_chk("R9 disabled again", 3'd4, 32'hFFFF_FFFE);
        rd_chk("R10 enable cleared", 3'd5, 32'h0FF);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule